// File: doc/BRIEF.md
# In-System Flash Programming Host Sequencer

This block drives a four-wire synchronous serial link (target reset, serial clock, data out, data in) from the programmer side and loads a target microcontroller's program flash. After a start command it pulses the target reset with the serial clock held low and waits a settle time. It then sends the programming-enable frame and checks the echo that a synchronised target returns. Once the link is up, it streams a number of 32-word pages from a local word buffer, commits each page and waits for the flash write to finish.

Every exchange is a 32-bit frame sent most significant bit first. The target samples data on the rising clock edge and the host changes it on the falling edge. The host captures the target's reply on each rising edge. If the echo is wrong, the sequencer still finishes the frame, pulses reset again and retries. After a bounded number of retries it gives up with an error flag. The buffer is read combinationally at address `{page, word}`. All timing (clock half period, reset pulse, settle delay, write delay) is set by parameters counted in system clock cycles.

Top module: `isp_host_seq`

## Requirements
- R1: While `rst_n` is low, `tgt_rst`, `tgt_sck`, `done` and `error` are 0, and they stay 0 in idle until `start`.
- R2: On `start`, `tgt_rst` goes high for exactly RST_PULSE cycles while `tgt_sck` stays low. No rising clock edge follows until at least SETTLE_CYC cycles after `tgt_rst` falls.
- R3: Within a frame, every high phase and every low phase of `tgt_sck` lasts exactly SCK_HALF cycles. `tgt_mosi` carries the frame MSB first and changes only while `tgt_sck` is low.
- R4: The enable frame is bytes 0xAC, 0x53, 0x00, 0x00. The byte sampled from `tgt_miso` during the third byte is compared with 0x53, and all 32 bits are sent whatever that byte holds.
- R5: On an echo mismatch the sequencer pulses `tgt_rst` again and reissues the enable frame. The failure after MAX_RETRY retries sets `error`, stops all link activity and keeps `error` until the next `start`, which clears it.
- R6: Each word is loaded by a low frame {0x40, 0x00, {3'b000, offset}, data[7:0]} followed by a high frame {0x48, 0x00, {3'b000, offset}, data[15:8]}. Offsets run 0 to 31 in ascending order, and the data is read at `buf_addr = {page[5:0], offset[4:0]}`.
- R7: After the 64 load frames of a page, the commit frame {0x4C, {5'b0, page[5:3]}, {page[2:0], 5'b0}, 0x00} is sent. Pages run from 0 to `page_count`-1.
- R8: After a commit frame, no rising clock edge occurs for at least WRITE_CYC cycles.
- R9: `done` pulses for exactly one cycle, never together with `error`. The pulse comes at least WRITE_CYC cycles after the last commit frame, or right after a good enable frame when `page_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a programming run (sampled in idle) |
| page_count | input | 7 | Number of pages to program (0 to 64) |
| buf_addr | output | 11 | Word buffer read address {page, offset} |
| buf_data | input | 16 | Word buffer read data, combinational from `buf_addr` |
| tgt_rst | output | 1 | Target reset pin level |
| tgt_sck | output | 1 | Serial clock to target |
| tgt_mosi | output | 1 | Serial data to target |
| tgt_miso | input | 1 | Serial data from target |
| done | output | 1 | One-cycle pulse when the run completes |
| error | output | 1 | Enable retries exhausted; held until next start |

## Verification
Runs are tried with zero, one and two pages, and with targets that withhold the echo for zero, one, two or three attempts. The page counts separate correct page indexing and the end-of-run decision, including the empty run. The echo failure counts separate success on first try, success on the last allowed retry and exhaustion into the error state. The buffer holds an address-dependent pattern, so a swapped byte order, a wrong offset or a misplaced page number shows up in the captured frames. Directed tests cover the quiet error state, the clear on restart and a reset in the middle of a page.

// File: rtl/isp_host_seq.sv
module isp_host_seq #(
  parameter int SCK_HALF   = 4,
  parameter int RST_PULSE  = 100,
  parameter int SETTLE_CYC = 2_000_000,
  parameter int WRITE_CYC  = 450_000,
  parameter int MAX_RETRY  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [6:0]  page_count,
  output logic [10:0] buf_addr,
  input  logic [15:0] buf_data,
  output logic        tgt_rst,
  output logic        tgt_sck,
  output logic        tgt_mosi,
  input  logic        tgt_miso,
  output logic        done,
  output logic        error
);
  localparam int LONG1 = SETTLE_CYC > WRITE_CYC ? SETTLE_CYC : WRITE_CYC;
  localparam int LONG  = LONG1 > RST_PULSE ? LONG1 : RST_PULSE;
  localparam int CW    = $clog2(LONG + 1);
  localparam int HW    = $clog2(SCK_HALF + 1);
  localparam int RW    = $clog2(MAX_RETRY + 1) + 1;

  typedef enum logic [2:0] {IDLE, PULSE, SETTLE, ENABLE, LOAD_LO, LOAD_HI, COMMIT, HOLD} state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [HW-1:0] tick;
  logic [5:0]    nbit;
  logic [31:0]   txs;
  logic [7:0]    echo;
  logic          busy, fin;
  logic [RW-1:0] tries;
  logic [6:0]    pages;
  logic [5:0]    page;
  logic [4:0]    word;
  logic [31:0]   frame;

  assign buf_addr = {page, word};
  assign tgt_mosi = txs[31];

  wire in_frame  = (st == ENABLE) || (st == LOAD_LO) || (st == LOAD_HI) || (st == COMMIT);
  wire launch    = in_frame && !busy && !fin;
  wire last_page = ({1'b0, page} == pages - 7'd1);

  always_comb begin
    case (st)
      ENABLE:  frame = 32'hAC53_0000;
      LOAD_LO: frame = {8'h40, 8'h00, 3'b000, word, buf_data[7:0]};
      LOAD_HI: frame = {8'h48, 8'h00, 3'b000, word, buf_data[15:8]};
      COMMIT:  frame = {8'h4C, 5'b00000, page[5:3], page[2:0], 5'b00000, 8'h00};
      default: frame = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txs <= '0; echo <= '0; busy <= 1'b0; fin <= 1'b0;
      tick <= '0; nbit <= '0; tgt_sck <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (launch) begin
        txs <= frame; busy <= 1'b1; tick <= '0; nbit <= '0;
      end else if (busy) begin
        if (tick == HW'(SCK_HALF - 1)) begin
          tick    <= '0;
          tgt_sck <= !tgt_sck;
          if (!tgt_sck) begin
            if (nbit[5:3] == 3'd2) echo <= {echo[6:0], tgt_miso};
          end else begin
            txs  <= {txs[30:0], 1'b0};
            nbit <= nbit + 6'd1;
            if (nbit == 6'd31) begin
              busy <= 1'b0;
              fin  <= 1'b1;
            end
          end
        end else begin
          tick <= tick + HW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; tries <= '0; pages <= '0; page <= '0; word <= '0;
      tgt_rst <= 1'b0; done <= 1'b0; error <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          st <= PULSE; cnt <= '0; tries <= '0; pages <= page_count;
          page <= '0; word <= '0; error <= 1'b0; tgt_rst <= 1'b1;
        end
        PULSE: if (cnt == CW'(RST_PULSE - 1)) begin
          cnt <= '0; tgt_rst <= 1'b0; st <= SETTLE;
        end else cnt <= cnt + CW'(1);
        SETTLE: if (cnt == CW'(SETTLE_CYC - 1)) begin
          cnt <= '0; st <= ENABLE;
        end else cnt <= cnt + CW'(1);
        ENABLE: if (fin) begin
          if (echo == 8'h53) begin
            if (pages == 7'd0) begin
              done <= 1'b1; st <= IDLE;
            end else st <= LOAD_LO;
          end else if (tries == RW'(MAX_RETRY)) begin
            error <= 1'b1; st <= IDLE;
          end else begin
            tries <= tries + RW'(1); tgt_rst <= 1'b1; cnt <= '0; st <= PULSE;
          end
        end
        LOAD_LO: if (fin) st <= LOAD_HI;
        LOAD_HI: if (fin) begin
          word <= word + 5'd1;
          st   <= (word == 5'd31) ? COMMIT : LOAD_LO;
        end
        COMMIT: if (fin) begin
          cnt <= '0; st <= HOLD;
        end
        HOLD: if (cnt == CW'(WRITE_CYC - 1)) begin
          cnt <= '0;
          if (last_page) begin
            done <= 1'b1; st <= IDLE;
          end else begin
            page <= page + 6'd1; st <= LOAD_LO;
          end
        end else cnt <= cnt + CW'(1);
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module isp_host_seq_chk #(
  parameter int SCK_HALF = 4
) (
  input logic clk,
  input logic rst_n,
  input logic tgt_rst,
  input logic tgt_sck,
  input logic tgt_mosi,
  input logic done,
  input logic error
);
  localparam int HW = $clog2(SCK_HALF + 1) + 1;
  logic          sck_q;
  logic [HW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0; run <= HW'(SCK_HALF);
    end else begin
      sck_q <= tgt_sck;
      if (tgt_sck != sck_q) run <= HW'(1);
      else if (run < HW'(SCK_HALF)) run <= run + HW'(1);
    end
  end

  assert_sck_low_in_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_rst |-> !tgt_sck);
  assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sck |-> $stable(tgt_mosi));
  assert_phase_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_sck != sck_q) |-> (run >= HW'(SCK_HALF)));
  assert_error_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (!tgt_sck && !tgt_rst));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_not_error_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !error);
endmodule

bind isp_host_seq isp_host_seq_chk #(.SCK_HALF(SCK_HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .tgt_rst(tgt_rst), .tgt_sck(tgt_sck),
  .tgt_mosi(tgt_mosi), .done(done), .error(error)
);

// File: tb/tb_isp_host_seq.sv
`timescale 1ns/1ps
module tb_isp_host_seq;
  localparam int SCK_HALF = 2, RST_PULSE = 5, SETTLE_CYC = 40, WRITE_CYC = 25, MAX_RETRY = 2;

  logic clk = 0, rst_n = 0, start = 0;
  logic [6:0] page_count = 0;
  logic [10:0] buf_addr;
  logic [15:0] buf_data;
  logic tgt_rst, tgt_sck, tgt_mosi, done, error;
  logic tgt_miso = 0;

  always #5 clk = ~clk;

  function automatic logic [15:0] memf(logic [10:0] a);
    logic [15:0] t;
    t = {5'b0, a} * 16'h9E37;
    return t ^ 16'h5A5A;
  endfunction
  assign buf_data = memf(buf_addr);

  isp_host_seq #(.SCK_HALF(SCK_HALF), .RST_PULSE(RST_PULSE), .SETTLE_CYC(SETTLE_CYC),
                 .WRITE_CYC(WRITE_CYC), .MAX_RETRY(MAX_RETRY)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .page_count(page_count), .buf_addr(buf_addr),
    .buf_data(buf_data), .tgt_rst(tgt_rst), .tgt_sck(tgt_sck), .tgt_mosi(tgt_mosi),
    .tgt_miso(tgt_miso), .done(done), .error(error));

  int checks = 0, failures = 0, cyc = 0;
  int bc = 0, nfr = 0, fail_left = 0, last_rise = 0, last_fall = 0, rst_rise_cyc = 0, rst_fall_cyc = 0;
  int phase_err = 0, pulse_err = 0, settle_err = 0, gap_err = 0, rst_pulses = 0, sck_rises = 0;
  int done_cnt = 0, done_cyc = 0;
  bit await_first = 0, after_wr = 0;
  logic [31:0] cap = 0;
  logic [7:0] echo_b = 0;
  logic [31:0] fr [0:255];

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (done) begin done_cnt++; done_cyc = cyc; end
  end

  always @(posedge tgt_sck) begin
    logic [31:0] f;
    if (bc > 0 && cyc - last_fall != SCK_HALF) phase_err++;
    if (bc == 0 && after_wr && cyc - last_rise < WRITE_CYC) gap_err++;
    if (bc == 0) after_wr = 0;
    if (await_first) begin
      if (cyc - rst_fall_cyc < SETTLE_CYC) settle_err++;
      await_first = 0;
    end
    sck_rises++;
    last_rise = cyc;
    f = {cap[30:0], tgt_mosi};
    cap = f;
    bc++;
    if (bc == 32) begin
      bc = 0;
      if (nfr < 256) fr[nfr] = f;
      nfr++;
      if (f[31:24] == 8'h4C) after_wr = 1;
      if (f[31:24] == 8'hAC && fail_left > 0) fail_left--;
    end
  end

  always @(negedge tgt_sck) begin
    if (cyc - last_rise != SCK_HALF) phase_err++;
    last_fall = cyc;
    if (bc == 16) echo_b = (fail_left > 0) ? 8'hA5 : cap[7:0];
    tgt_miso = (bc >= 16 && bc < 24) ? echo_b[23 - bc] : 1'b0;
  end

  always @(posedge tgt_rst) begin
    rst_rise_cyc = cyc; rst_pulses++; bc = 0;
  end
  always @(negedge tgt_rst) begin
    if (cyc - rst_rise_cyc != RST_PULSE) pulse_err++;
    rst_fall_cyc = cyc; await_first = 1;
  end

  function automatic logic [31:0] expf(int idx, int att);
    int j, p, k, w;
    logic [15:0] d;
    if (idx < att) return 32'hAC53_0000;
    j = idx - att; p = j / 65; k = j % 65;
    if (k == 64) return {8'h4C, 5'b0, p[5:3], p[2:0], 5'b0, 8'h00};
    w = k / 2;
    d = memf({p[5:0], w[4:0]});
    if (k % 2 == 0) return {8'h40, 8'h00, 3'b000, w[4:0], d[7:0]};
    return {8'h48, 8'h00, 3'b000, w[4:0], d[15:8]};
  endfunction

  // Scenario table: {pages[6:0], withheld echoes[3:0], expect_error}
  localparam logic [11:0] VEC [0:4] = '{
    {7'd1, 4'd0, 1'b0}, {7'd2, 4'd1, 1'b0}, {7'd0, 4'd0, 1'b0},
    {7'd1, 4'd2, 1'b0}, {7'd0, 4'd3, 1'b1}};

  task automatic run_case(int pages, int fails, bit experr);
    int att, expn, mis_en, mis_ld, mis_wr, t;
    logic [31:0] e;
    nfr = 0; fail_left = fails; phase_err = 0; pulse_err = 0; settle_err = 0; gap_err = 0;
    rst_pulses = 0; done_cnt = 0; after_wr = 0; bc = 0;
    @(posedge clk); #1 page_count = 7'(pages); start = 1;
    @(posedge clk); #1 start = 0;
    t = 0;
    while (!(done || error) && t < 60000) begin @(negedge clk); t++; end
    chk(t < 60000, "R9 run completion", t, 0);
    repeat (40) @(negedge clk);
    att  = experr ? MAX_RETRY + 1 : fails + 1;
    expn = att + (experr ? 0 : pages * 65);
    chk(error == experr, "R5 error flag", error, experr);
    chk(done_cnt == (experr ? 0 : 1), "R9 done pulses", done_cnt, experr ? 0 : 1);
    chk(rst_pulses == att, "R5 reset pulses", rst_pulses, att);
    chk(nfr == expn, "R4 R6 R7 frame count", nfr, expn);
    mis_en = 0; mis_ld = 0; mis_wr = 0;
    for (int i = 0; i < nfr && i < expn && i < 256; i++) begin
      e = expf(i, att);
      if (fr[i] != e) begin
        if (e[31:24] == 8'hAC) mis_en++;
        else if (e[31:24] == 8'h4C) mis_wr++;
        else mis_ld++;
      end
    end
    chk(mis_en == 0, "R4 enable frames", mis_en, 0);
    chk(mis_ld == 0, "R6 load frames", mis_ld, 0);
    chk(mis_wr == 0, "R7 commit frames", mis_wr, 0);
    chk(pulse_err == 0, "R2 reset pulse width", pulse_err, 0);
    chk(settle_err == 0, "R2 settle delay", settle_err, 0);
    chk(phase_err == 0, "R3 clock phase width", phase_err, 0);
    chk(gap_err == 0, "R8 commit wait", gap_err, 0);
    if (!experr && pages > 0)
      chk(done_cyc - last_rise >= WRITE_CYC, "R9 done after write wait", done_cyc - last_rise, WRITE_CYC);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int r;
    repeat (3) @(negedge clk);
    chk(tgt_rst == 0 && tgt_sck == 0, "R1 pins in reset", {tgt_rst, tgt_sck}, 0);
    chk(done == 0 && error == 0, "R1 flags in reset", {done, error}, 0);
    #1 rst_n = 1;
    repeat (20) @(negedge clk);
    chk(tgt_rst == 0 && tgt_sck == 0 && done == 0, "R1 idle before start", {tgt_rst, tgt_sck, done}, 0);

    foreach (VEC[i]) run_case(int'(VEC[i][11:5]), int'(VEC[i][4:1]), VEC[i][0]);

    // R5: after the error the link stays quiet and the flag holds
    r = sck_rises;
    repeat (300) @(negedge clk);
    chk(sck_rises == r, "R5 no clock after error", sck_rises - r, 0);
    chk(error == 1 && tgt_rst == 0, "R5 error held", error, 1);
    @(posedge clk); #1 page_count = 7'd1; start = 1;
    @(posedge clk); #1 start = 0;
    @(negedge clk);
    chk(error == 0, "R5 error cleared by start", error, 0);

    // R1: reset in the middle of a page
    fail_left = 0;
    repeat (3000) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(tgt_rst == 0 && tgt_sck == 0 && done == 0 && error == 0, "R1 reset mid-run",
        {tgt_rst, tgt_sck, done, error}, 0);
    #1 rst_n = 1;
    repeat (100) @(negedge clk);
    chk(tgt_sck == 0 && done == 0, "R1 idle after reset", {tgt_sck, done}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule